// File: doc/BRIEF.md
# Extended-Address Decode and Generation Unit

This unit sits beside the integer pipeline of a 64-bit core that carries a second file of 32 extended registers. Each extended register pairs with the general register of the same index. The unit decodes the instructions that use extended addressing and forms a 128-bit effective address from two parts. The upper half is an extended register. The lower half is a general register, with or without a sign-extended 12-bit offset. The unit reports the size of the access, whether it is a read or a write, whether the data is unsigned, and whether the data register is an extended register.

The unit also owns the extended register file. Two kinds of instruction write that file: the address-management add, which writes a general register plus an immediate, and the loads that target an extended register. A write is committed on the retire strobe of the instruction presented in that cycle. The instruction decoded in the following cycle already sees the written value. All entries are cleared by reset, so plain 64-bit code forms addresses with an upper half of zero.

The core supplies the values of the general registers named in the rs1 and rs2 fields. For extended-register loads it also supplies the returned load data. Data-path sign extension, the memory system and base-ISA decode stay outside the unit.

Top module: `xa_unit`

## Requirements
- R1: After reset every extended register reads as zero, so the upper 64 address bits are zero for any index until that register is written.
- R2: Opcode 1110111 (immediate load) forms the address with bits [127:64] taken from the extended register indexed by the rs1 field (instr[19:15]) and bits [63:0] = gpr_a + sign-extended instr[31:20], wrapping modulo 2^64.
- R3: For immediate and raw loads, funct3 (instr[14:12]) maps to size codes (0 byte, 1 half, 2 word, 3 double, 4 quad) as 000→0, 001→1, 010→2, 011→3, 100→0 unsigned, 101→1 unsigned, 110→4. The request is a read, and req_unsigned is high only for 100 and 101.
- R4: Opcode 1111011 (immediate store) is a write. Bits [127:64] come from the extended register indexed by rs2 (instr[24:20]) and bits [63:0] = gpr_b + sign-extended {instr[31:25], instr[11:7]}. funct3 000..100 gives size code equal to funct3. funct3 101 stores the extended register indexed by rs1 with size 3, req_ext high and its value on st_ext_data. funct3 110 and 111 are illegal.
- R5: Opcode 0111111 (raw form) uses no offset. Bits [63:0] equal gpr_a exactly, and bits [127:64] are the extended register named by the rs2 field.
- R6: In the raw form, funct7 (instr[31:25]) selects the operation. 0000010 is a load using the R3 size map, with funct3 111 illegal. 0000100 is a store of size funct3 for funct3 ≤ 100. 0000011 with funct3 100 is an extended-register load of size 3. 0001000 with funct3 011 is an extended-register store of size 3, with data from the extended register named by the rd field. Any other raw combination is illegal.
- R7: Opcode 1011011 with funct3 000 (address-management add) makes no memory request. On retire it writes gpr_a + sign-extended instr[31:20] into extended register rd. Any other funct3 with this opcode is illegal.
- R8: An extended-register load (immediate funct3 111, or raw funct7 0000011) writes ld_data into extended register rd when retired.
- R9: An extended-register write happens only when retire is high. Without retire, ext_we stays low and the register keeps its value.
- R10: An instruction decoded in the cycle after a retired write sees the new value in both address and store-data reads. Entry 0 is writable like any other.
- R11: An illegal combination raises illegal, makes no request and leaves ext_we low even with retire high.
- R12: Any opcode outside the four above makes no request, no write and no illegal indication.
- R13: req_reg_idx names the data register: rd for loads, rs1 for immediate stores, rd for raw stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word in decode |
| gpr_a | input | 64 | Value of the general register named by rs1 |
| gpr_b | input | 64 | Value of the general register named by rs2 |
| retire | input | 1 | The presented instruction completes this cycle |
| ld_data | input | 64 | Returned data for an extended-register load |
| req_valid | output | 1 | A memory request is described |
| req_write | output | 1 | 1 for store, 0 for load |
| req_size | output | 3 | Size code: 0 byte, 1 half, 2 word, 3 double, 4 quad |
| req_unsigned | output | 1 | Load data is zero-extended |
| req_ext | output | 1 | Data register is an extended register |
| req_addr | output | 128 | Effective address |
| req_reg_idx | output | 5 | Data register index |
| st_ext_data | output | 64 | Extended register value for extended stores |
| illegal | output | 1 | Unsupported extension encoding |
| ext_we | output | 1 | Extended register write commits at this edge |
| ext_widx | output | 5 | Index of the written extended register |
| ext_wdata | output | 64 | Value written |

## Verification
The bench builds the unit with its default parameters: 64-bit registers, 32 extended entries and the bypass enabled. With the bypass on, a reference model that updates at the retire edge predicts every following decode exactly. Any back-to-back dependency in the random stream, including writes to entry 0 followed at once by a read, therefore tests R10. With 32 entries, a short directed sweep covers every index after reset. The random mix weights address-management writes heavily so that the upper address halves soon carry distinct non-zero values.

// File: rtl/xa_pkg.sv
// Package: encodings and decoded-control record shared by the
// extended-address unit. Assumes 32-bit instruction words with the
// usual opcode/rd/funct3/rs1/rs2/funct7 field positions.
package xa_pkg;

    localparam logic [6:0] OP_LOAD_IMM  = 7'b1110111;
    localparam logic [6:0] OP_STORE_IMM = 7'b1111011;
    localparam logic [6:0] OP_RAW       = 7'b0111111;
    localparam logic [6:0] OP_EADD      = 7'b1011011;

    localparam logic [6:0] F7_RAW_LD    = 7'b0000010;
    localparam logic [6:0] F7_RAW_ELD   = 7'b0000011;
    localparam logic [6:0] F7_RAW_ST    = 7'b0000100;
    localparam logic [6:0] F7_RAW_EST   = 7'b0001000;

    localparam logic [2:0] SZ_BYTE   = 3'd0;
    localparam logic [2:0] SZ_HALF   = 3'd1;
    localparam logic [2:0] SZ_WORD   = 3'd2;
    localparam logic [2:0] SZ_DOUBLE = 3'd3;
    localparam logic [2:0] SZ_QUAD   = 3'd4;

    typedef struct packed {
        logic        mem;      // a memory request is described
        logic        wr;       // request writes memory
        logic [2:0]  size;     // size code
        logic        uns;      // zero-extending load
        logic        ext;      // data register is extended
        logic        illegal;  // unsupported encoding
        logic        ext_wr;   // writes an extended register on retire
        logic        wsel_mem; // write value is returned load data
        logic        base_b;   // lower base is gpr_b instead of gpr_a
        logic        use_imm;  // add the 12-bit offset
        logic [4:0]  hi_idx;   // extended register for the upper half
        logic [4:0]  reg_idx;  // data register index
        logic [4:0]  src_idx;  // extended register read for store data
        logic [4:0]  wr_idx;   // extended register written
        logic [11:0] imm;      // raw 12-bit offset
    } dec_t;

endpackage

// File: rtl/xa_decode.sv
// Module: instruction decoder for the extended-address instructions.
// Purely combinational; produces an all-zero record for foreign
// opcodes and a record with only 'illegal' set for unsupported
// combinations inside the extension's opcodes.
module xa_decode
    import xa_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [6:0] opc;
    logic [4:0] f_rd;
    logic [2:0] f3;
    logic [4:0] f_rs1;
    logic [4:0] f_rs2;
    logic [6:0] f7;

    assign opc   = instr[6:0];
    assign f_rd  = instr[11:7];
    assign f3    = instr[14:12];
    assign f_rs1 = instr[19:15];
    assign f_rs2 = instr[24:20];
    assign f7    = instr[31:25];

    // Shared load size map: funct3 -> {size, unsigned}, 111 flagged separately.
    function automatic logic [3:0] load_map(input logic [2:0] code);
        case (code)
            3'b000:  load_map = {SZ_BYTE,   1'b0};
            3'b001:  load_map = {SZ_HALF,   1'b0};
            3'b010:  load_map = {SZ_WORD,   1'b0};
            3'b011:  load_map = {SZ_DOUBLE, 1'b0};
            3'b100:  load_map = {SZ_BYTE,   1'b1};
            3'b101:  load_map = {SZ_HALF,   1'b1};
            default: load_map = {SZ_QUAD,   1'b0};
        endcase
    endfunction

    // Decode opcode, funct3 and funct7 into the control record.
    always_comb begin
        dec = '0;
        unique case (opc)
            OP_LOAD_IMM: begin
                dec.mem     = 1'b1;
                dec.use_imm = 1'b1;
                dec.imm     = instr[31:20];
                dec.hi_idx  = f_rs1;
                dec.reg_idx = f_rd;
                dec.wr_idx  = f_rd;
                if (f3 == 3'b111) begin
                    dec.size     = SZ_DOUBLE;
                    dec.ext      = 1'b1;
                    dec.ext_wr   = 1'b1;
                    dec.wsel_mem = 1'b1;
                end else begin
                    {dec.size, dec.uns} = load_map(f3);
                end
            end
            OP_STORE_IMM: begin
                dec.wr      = 1'b1;
                dec.use_imm = 1'b1;
                dec.base_b  = 1'b1;
                dec.imm     = {instr[31:25], instr[11:7]};
                dec.hi_idx  = f_rs2;
                dec.reg_idx = f_rs1;
                dec.src_idx = f_rs1;
                if (f3 <= 3'b100) begin
                    dec.mem  = 1'b1;
                    dec.size = f3;
                end else if (f3 == 3'b101) begin
                    dec.mem  = 1'b1;
                    dec.size = SZ_DOUBLE;
                    dec.ext  = 1'b1;
                end else begin
                    dec = '0;
                    dec.illegal = 1'b1;
                end
            end
            OP_RAW: begin
                dec.hi_idx  = f_rs2;
                dec.reg_idx = f_rd;
                dec.src_idx = f_rd;
                dec.wr_idx  = f_rd;
                if (f7 == F7_RAW_LD && f3 != 3'b111) begin
                    dec.mem = 1'b1;
                    {dec.size, dec.uns} = load_map(f3);
                end else if (f7 == F7_RAW_ST && f3 <= 3'b100) begin
                    dec.mem  = 1'b1;
                    dec.wr   = 1'b1;
                    dec.size = f3;
                end else if (f7 == F7_RAW_ELD && f3 == 3'b100) begin
                    dec.mem      = 1'b1;
                    dec.size     = SZ_DOUBLE;
                    dec.ext      = 1'b1;
                    dec.ext_wr   = 1'b1;
                    dec.wsel_mem = 1'b1;
                end else if (f7 == F7_RAW_EST && f3 == 3'b011) begin
                    dec.mem  = 1'b1;
                    dec.wr   = 1'b1;
                    dec.size = SZ_DOUBLE;
                    dec.ext  = 1'b1;
                end else begin
                    dec = '0;
                    dec.illegal = 1'b1;
                end
            end
            OP_EADD: begin
                if (f3 == 3'b000) begin
                    dec.ext_wr  = 1'b1;
                    dec.use_imm = 1'b1;
                    dec.imm     = instr[31:20];
                    dec.wr_idx  = f_rd;
                end else begin
                    dec.illegal = 1'b1;
                end
            end
            default: dec = '0;
        endcase
    end

endmodule

// File: rtl/xa_ext_rf.sv
// Module: extended register file with one write port and NRD read
// ports. A write is parked in a one-entry staging register at the
// edge it arrives and copied into the array at the next edge. When
// BYPASS is set, reads match the staged entry first, so the very
// next cycle observes the new value. Reset clears all state.
module xa_ext_rf #(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int NRD    = 2,
    parameter bit BYPASS = 1'b1,
    localparam int IDXW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IDXW-1:0] rd_idx  [NRD],
    output logic [XLEN-1:0] rd_data [NRD]
);

    logic [XLEN-1:0] ent [NREG];
    logic            stg_vld;
    logic [IDXW-1:0] stg_idx;
    logic [XLEN-1:0] stg_data;

    // Capture an incoming write into the staging slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg_idx  <= '0;
            stg_data <= '0;
        end else begin
            stg_vld  <= wr_en;
            stg_idx  <= wr_idx;
            stg_data <= wr_data;
        end
    end

    // Retire the staged write into the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) ent[i] <= '0;
        end else if (stg_vld) begin
            ent[stg_idx] <= stg_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        if (BYPASS) begin : g_byp
            // Read with staged-entry forwarding.
            always_comb begin
                if (stg_vld && stg_idx == rd_idx[p]) rd_data[p] = stg_data;
                else                                 rd_data[p] = ent[rd_idx[p]];
            end

            AST_BYPASS_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> ((rd_idx[p] != $past(wr_idx)) || (rd_data[p] == $past(wr_data)))); // R10
        end else begin : g_plain
            // Read the array only; staged writes appear one cycle later.
            always_comb rd_data[p] = ent[rd_idx[p]];
        end

        AST_CLEARED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (rd_data[p] == '0)); // R1
    end

endmodule

// File: rtl/xa_addr_gen.sv
// Module: effective-address former. Adds the selected general
// register and the optional sign-extended offset, and places the
// extended register value above it. The same sum doubles as the
// write value of the address-management add.
module xa_addr_gen #(
    parameter int XLEN = 64,
    parameter int IMMW = 12,
    localparam int AW  = 2 * XLEN
) (
    input  logic [XLEN-1:0] gpr_a,
    input  logic [XLEN-1:0] gpr_b,
    input  logic            base_b,
    input  logic            use_imm,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] upper,
    output logic [XLEN-1:0] lower_sum,
    output logic [AW-1:0]   addr
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    // Select base and sign-extend the offset, then add.
    always_comb begin
        base      = base_b ? gpr_b : gpr_a;
        offs      = use_imm ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : '0;
        lower_sum = base + offs;
        addr      = {upper, lower_sum};
    end

endmodule

// File: rtl/xa_unit.sv
// Module: top of the extended-address decode and generation unit.
// Decodes the presented instruction, reads the extended register
// file for the upper address half and for extended store data,
// forms the 128-bit address and drives the extended write on retire.
// Assumes gpr_a/gpr_b already hold the registers named by rs1/rs2.
module xa_unit
    import xa_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter bit BYPASS = 1'b1,
    localparam int AW    = 2 * XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] gpr_a,
    input  logic [XLEN-1:0] gpr_b,
    input  logic            retire,
    input  logic [XLEN-1:0] ld_data,
    output logic            req_valid,
    output logic            req_write,
    output logic [2:0]      req_size,
    output logic            req_unsigned,
    output logic            req_ext,
    output logic [AW-1:0]   req_addr,
    output logic [4:0]      req_reg_idx,
    output logic [XLEN-1:0] st_ext_data,
    output logic            illegal,
    output logic            ext_we,
    output logic [4:0]      ext_widx,
    output logic [XLEN-1:0] ext_wdata
);

    dec_t            dec;
    logic [4:0]      rd_idx  [2];
    logic [XLEN-1:0] rd_data [2];
    logic [XLEN-1:0] lower_sum;

    xa_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    // Port 0 feeds the upper address half, port 1 the store data.
    always_comb begin
        rd_idx[0] = dec.hi_idx;
        rd_idx[1] = dec.src_idx;
    end

    xa_ext_rf #(
        .XLEN   (XLEN),
        .NREG   (NREG),
        .NRD    (2),
        .BYPASS (BYPASS)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ext_we),
        .wr_idx  (ext_widx),
        .wr_data (ext_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    xa_addr_gen #(
        .XLEN (XLEN),
        .IMMW (12)
    ) u_agen (
        .gpr_a     (gpr_a),
        .gpr_b     (gpr_b),
        .base_b    (dec.base_b),
        .use_imm   (dec.use_imm),
        .imm       (dec.imm),
        .upper     (rd_data[0]),
        .lower_sum (lower_sum),
        .addr      (req_addr)
    );

    // Drive request descriptor fields from the decoded record.
    always_comb begin
        req_valid    = dec.mem;
        req_write    = dec.wr;
        req_size     = dec.size;
        req_unsigned = dec.uns;
        req_ext      = dec.ext;
        req_reg_idx  = dec.reg_idx;
        st_ext_data  = rd_data[1];
        illegal      = dec.illegal;
    end

    // Extended write controls: commit only on retire.
    always_comb begin
        ext_we    = dec.ext_wr && retire;
        ext_widx  = dec.wr_idx;
        ext_wdata = dec.wsel_mem ? ld_data : lower_sum;
    end

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!req_valid && !ext_we)); // R11

    AST_WRITE_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we |-> retire); // R9

    AST_RAW_LOWER_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && instr[6:0] == OP_RAW) |-> (req_addr[XLEN-1:0] == gpr_a)); // R5

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[6:0] != OP_RAW && instr[6:0] != OP_LOAD_IMM &&
         instr[6:0] != OP_STORE_IMM && instr[6:0] != OP_EADD)
        |-> (!illegal && !req_valid && !ext_we)); // R12

endmodule

// File: tb/xa_unit_tb_top.sv
`timescale 1ns/1ps
module xa_unit_tb_top;

    localparam logic [6:0] LDI = 7'b1110111;
    localparam logic [6:0] STI = 7'b1111011;
    localparam logic [6:0] RAW = 7'b0111111;
    localparam logic [6:0] EAD = 7'b1011011;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  instr = '0;
    logic [63:0]  gpr_a = '0, gpr_b = '0, ld_data = '0;
    logic         retire = 1'b0;
    logic         req_valid, req_write, req_unsigned, req_ext, illegal, ext_we;
    logic [2:0]   req_size;
    logic [127:0] req_addr;
    logic [4:0]   req_reg_idx, ext_widx;
    logic [63:0]  st_ext_data, ext_wdata;

    int nchk = 0;
    int nerr = 0;

    logic [63:0] model [32];

    // expected values
    logic         e_valid, e_wr, e_uns, e_ext, e_ill, e_we, e_est;
    logic [2:0]   e_size;
    logic [127:0] e_addr;
    logic [4:0]   e_reg, e_widx;
    logic [63:0]  e_wdata, e_sted;
    string        e_tag;

    always #2 clk = ~clk;

    xa_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .gpr_a(gpr_a), .gpr_b(gpr_b),
        .retire(retire), .ld_data(ld_data), .req_valid(req_valid),
        .req_write(req_write), .req_size(req_size), .req_unsigned(req_unsigned),
        .req_ext(req_ext), .req_addr(req_addr), .req_reg_idx(req_reg_idx),
        .st_ext_data(st_ext_data), .illegal(illegal), .ext_we(ext_we),
        .ext_widx(ext_widx), .ext_wdata(ext_wdata)
    );

    function automatic logic [31:0] enc_i(input logic [6:0] op, input logic [4:0] rd,
                                          input logic [2:0] f3, input logic [4:0] rs1,
                                          input logic [11:0] imm);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_s(input logic [2:0] f3, input logic [4:0] rs1,
                                          input logic [4:0] rs2, input logic [11:0] imm);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], STI};
    endfunction

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, RAW};
    endfunction

    function automatic logic [63:0] sx12(input logic [11:0] v);
        return {{52{v[11]}}, v};
    endfunction

    // Load size map from R3.
    task automatic load_size(input logic [2:0] f3);
        case (f3)
            3'd4: begin e_size = 3'd0; e_uns = 1'b1; end
            3'd5: begin e_size = 3'd1; e_uns = 1'b1; end
            3'd6: e_size = 3'd4;
            default: e_size = f3;
        endcase
    endtask

    task automatic predict(input logic [31:0] ins, input logic [63:0] a, b, ld, input logic ret);
        logic [6:0] op;
        logic [4:0] rd, rs1, rs2;
        logic [2:0] f3;
        logic [6:0] f7;
        logic ewr;
        op = ins[6:0]; rd = ins[11:7]; f3 = ins[14:12];
        rs1 = ins[19:15]; rs2 = ins[24:20]; f7 = ins[31:25];
        e_valid = 0; e_wr = 0; e_uns = 0; e_ext = 0; e_ill = 0; e_est = 0;
        e_size = 0; e_addr = '0; e_reg = 0; e_sted = '0; ewr = 0;
        e_widx = rd; e_wdata = ld; e_tag = "R12";
        case (op)
            LDI: begin
                e_valid = 1; e_reg = rd; e_tag = "R3";
                e_addr = {model[rs1], a + sx12(ins[31:20])};
                if (f3 == 3'd7) begin e_size = 3; e_ext = 1; ewr = 1; e_tag = "R8"; end
                else load_size(f3);
            end
            STI: begin
                e_tag = "R4"; e_reg = rs1;
                e_addr = {model[rs2], b + sx12({ins[31:25], ins[11:7]})};
                if (f3 <= 3'd4) begin e_valid = 1; e_wr = 1; e_size = f3; end
                else if (f3 == 3'd5) begin
                    e_valid = 1; e_wr = 1; e_size = 3; e_ext = 1; e_est = 1; e_sted = model[rs1];
                end else e_ill = 1;
            end
            RAW: begin
                e_tag = "R6"; e_reg = rd; e_addr = {model[rs2], a};
                if (f7 == 7'd2 && f3 != 3'd7) begin e_valid = 1; load_size(f3); end
                else if (f7 == 7'd4 && f3 <= 3'd4) begin e_valid = 1; e_wr = 1; e_size = f3; end
                else if (f7 == 7'd3 && f3 == 3'd4) begin
                    e_valid = 1; e_size = 3; e_ext = 1; ewr = 1; e_tag = "R8";
                end else if (f7 == 7'd8 && f3 == 3'd3) begin
                    e_valid = 1; e_wr = 1; e_size = 3; e_ext = 1; e_est = 1; e_sted = model[rd];
                end else e_ill = 1;
            end
            EAD: begin
                e_tag = "R7";
                if (f3 == 3'd0) begin ewr = 1; e_wdata = a + sx12(ins[31:20]); end
                else e_ill = 1;
            end
            default: ;
        endcase
        if (e_ill) e_tag = "R11";
        e_we = ewr && ret;
    endtask

    task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Present one instruction, check outputs mid-cycle, update model at the edge.
    task automatic step(input logic [31:0] ins, input logic [63:0] a, b, ld,
                        input logic ret, input string tag_o);
        string t;
        @(negedge clk);
        instr = ins; gpr_a = a; gpr_b = b; ld_data = ld; retire = ret;
        predict(ins, a, b, ld, ret);
        t = (tag_o == "") ? e_tag : tag_o;
        #1;
        chk(t, "illegal", illegal, e_ill);
        chk(t, "req_valid", req_valid, e_valid);
        if (e_valid) begin
            chk(t, "req_write", req_write, e_wr);
            chk(t, "req_size", req_size, e_size);
            chk(t, "req_unsigned", req_unsigned, e_uns);
            chk(t, "req_ext", req_ext, e_ext);
            chk((t == "R3" || t == "R6") ? "R2" : t, "req_addr", req_addr, e_addr);
            chk("R13", "req_reg_idx", req_reg_idx, e_reg);
            if (e_est) chk(t, "st_ext_data", st_ext_data, e_sted);
        end
        chk((e_we || ext_we) ? t : "R9", "ext_we", ext_we, e_we);
        if (e_we) begin
            chk(t, "ext_widx", ext_widx, e_widx);
            chk(t, "ext_wdata", ext_wdata, e_wdata);
        end
        @(posedge clk);
        if (e_we) model[e_widx] = e_wdata;
    endtask

    initial begin
        #800000;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] ins;
        logic [6:0]  f7, op;
        void'($urandom(32'h1bad5eed));
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: every entry reads zero after reset (raw double load sweep)
        for (int i = 0; i < 32; i++)
            step(enc_r(7'd2, 5'(i), 5'd3, 3'd3, 5'd1), 64'h1234, 64'h0, 64'h0, 1'b0, "R1");

        // R10: write entry 0, read it in the very next cycle
        step(enc_i(EAD, 5'd0, 3'd0, 5'd0, 12'd5), 64'h0, 64'h0, 64'h0, 1'b1, "R7");
        step(enc_r(7'd2, 5'd0, 5'd4, 3'd3, 5'd2), 64'hAA, 64'h0, 64'h0, 1'b0, "R10");

        // R9: no retire, no write
        step(enc_i(EAD, 5'd7, 3'd0, 5'd1, 12'h3FF), 64'h99, 64'h0, 64'h0, 1'b0, "R9");
        step(enc_r(7'd2, 5'd7, 5'd4, 3'd3, 5'd2), 64'h1, 64'h0, 64'h0, 1'b0, "R9");

        // R8: extended-register load then immediate use as store data (R10)
        step(enc_i(LDI, 5'd9, 3'd7, 5'd0, 12'd8), 64'h40, 64'h0, 64'hDEAD_BEEF_0123_4567, 1'b1, "R8");
        step(enc_s(3'd5, 5'd9, 5'd0, 12'hFF0), 64'h0, 64'h100, 64'h0, 1'b0, "R10");

        // R11: illegal raw funct7 with retire
        step(enc_r(7'd1, 5'd2, 5'd3, 3'd0, 5'd4), 64'h5, 64'h6, 64'h7, 1'b1, "R11");
        step(enc_s(3'd6, 5'd1, 5'd2, 12'd0), 64'h5, 64'h6, 64'h7, 1'b1, "R11");

        // R2: negative offset wraps below zero
        step(enc_i(LDI, 5'd3, 3'd4, 5'd0, 12'hFFF), 64'h0, 64'h0, 64'h0, 1'b0, "R2");

        // R12: foreign opcode with retire
        step(32'h0000_0013, 64'h5, 64'h6, 64'h7, 1'b1, "R12");

        for (int n = 0; n < 4000; n++) begin
            int cls;
            cls = $urandom % 8;
            ins = $urandom;
            case (cls)
                0: ins[6:0] = LDI;
                1: ins[6:0] = STI;
                2, 3: begin
                    ins[6:0] = RAW;
                    case ($urandom % 5)
                        0: f7 = 7'd2;
                        1: f7 = 7'd3;
                        2: f7 = 7'd4;
                        3: f7 = 7'd8;
                        default: f7 = 7'($urandom);
                    endcase
                    ins[31:25] = f7;
                end
                4, 5, 6: begin
                    ins[6:0] = EAD;
                    if ($urandom % 8 != 0) ins[14:12] = 3'd0;
                end
                default: begin
                    op = 7'($urandom);
                    while (op == LDI || op == STI || op == RAW || op == EAD) op = 7'($urandom);
                    ins[6:0] = op;
                end
            endcase
            step(ins, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
                 1'($urandom % 4 != 0), "");
        end

        @(negedge clk); retire = 1'b0;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule